// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received Ethernet frame that carries a group (multicast) destination address should be kept. The destination address bytes arrive one per valid cycle, and the first byte is flagged by a start-of-frame marker. The bytes are fed through the reflected Ethernet CRC-32, one bit per step, starting from an all-ones preset. Six bits of the final CRC value select one bit of a 64-bit hash table. A host loads that table through a narrow write port that holds eight 8-bit registers.

Two 3-bit reversals turn the 6-bit index into a register number and a bit position. A set table bit keeps the frame. A clear bit drops it silently. Frames whose destination is not a group address skip the lookup and are flagged as such, so that a separate unicast filter can handle them.

Each evaluation ends with a one-cycle done pulse. The accept and multicast flags are valid in the same cycle as that pulse. The lookup reads a private copy of the table taken at the start of the frame, so host writes never disturb an evaluation that is in flight.

Top module: `mcast_hash_filter`

## Requirements
- R1: The CRC uses the reflected polynomial 0xEDB88320 and is preset to 0xFFFFFFFF. Each byte is consumed least significant bit first. The CRC covers exactly the first 6 bytes of a frame, where byte 0 is the byte presented with `sof_i`. Bytes after the sixth and bytes seen before any start marker are ignored.
- R2: The hash index is bits [5:0] of the CRC register after the sixth byte, with no final inversion.
- R3: The table register is the 3-bit reversal of index bits [2:0] and the bit within it is the 3-bit reversal of index bits [5:3]. The reversal maps 0..7 to 0,4,2,6,1,5,3,7.
- R4: For a multicast frame, `accept_o` equals the selected table bit. An all-zero table rejects every multicast frame.
- R5: A frame is multicast when bit 0 of byte 0 is 1. Otherwise the frame is reported with `mcast_o`=0 and `accept_o`=0, whatever the table holds.
- R6: If the sixth byte is sampled at rising edge k, then `done_o`, `accept_o` and `mcast_o` update at edge k+1, and `done_o` is high for exactly one cycle. Idle cycles between bytes (`byte_vld_i`=0) are allowed.
- R7: A byte presented with `sof_i` before the sixth byte discards the partial calculation and restarts from the preset. Only the new frame produces a result.
- R8: A write stores `reg_wdata_i` into register `reg_addr_i`. Register r bit b is table bit 8*r+b. The write takes effect for the next frame whose start byte is sampled after the write edge. A write during an evaluation does not change that evaluation's result.
- R9: After reset, `done_o`, `accept_o` and `mcast_o` are 0 and the table is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Destination address byte |
| byte_vld_i | input | 1 | `byte_i` is valid this cycle |
| sof_i | input | 1 | Marks the valid byte as byte 0 of a new frame |
| reg_we_i | input | 1 | Table register write strobe |
| reg_addr_i | input | 3 | Table register number |
| reg_wdata_i | input | 8 | Table register write data |
| done_o | output | 1 | One-cycle pulse: result valid |
| accept_o | output | 1 | Frame kept by the hash filter |
| mcast_o | output | 1 | Destination was a group address |

## Verification
A sweep of 256 pseudo-random group addresses is the main test. Each address is run twice: once against a table holding only the bit the bench predicts, and once against a table holding every other bit. The pair separates a wrong CRC or a swapped reversal (the frame is kept by the wrong table) from a correct lookup. Individual addresses with the group bit clear, an all-zero table, and gaps between bytes check the bypass path and the fixed latency. Extra trailing bytes, an aborted partial frame, and a table write landing mid-frame check that only the intended six bytes and the frame-start table copy decide the result.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam logic [31:0] CRC_POLY   = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET = 32'hFFFFFFFF;

  // eight serial steps of the reflected recurrence, LSB first
  function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c  = {1'b0, c[31:1]} ^ (fb ? CRC_POLY : 32'h0);
    end
    return c;
  endfunction
endpackage

// File: rtl/mhf_addr_ctrl.sv
module mhf_addr_ctrl #(
  parameter int ADDR_BYTES = 6,
  localparam int CNT_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] byte_i,
  input  logic       byte_vld_i,
  input  logic       sof_i,
  output logic       start_o,
  output logic       adv_o,
  output logic       eval_o,
  output logic       mcast_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES);

  logic [CNT_W-1:0] cnt_q;
  logic             eval_q, mcast_q;

  assign start_o = byte_vld_i & sof_i;
  assign adv_o   = byte_vld_i & ~sof_i & (cnt_q != '0) & (cnt_q < LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      eval_q  <= 1'b0;
      mcast_q <= 1'b0;
    end else if (start_o) begin
      cnt_q   <= CNT_W'(1);
      mcast_q <= byte_i[0];
      eval_q  <= (ADDR_BYTES == 1);
    end else if (adv_o) begin
      cnt_q  <= cnt_q + CNT_W'(1);
      eval_q <= (cnt_q + CNT_W'(1) == LAST);
    end else begin
      eval_q <= 1'b0;
    end
  end

  assign eval_o  = eval_q;
  assign mcast_o = mcast_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R7
  AST_EVAL_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_q |-> cnt_q == LAST); // R1
  AST_NO_ADV_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST && !sof_i) |=> $stable(cnt_q)); // R1
endmodule

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine
  import mhf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  byte_i,
  input  logic        start_i,
  input  logic        adv_i,
  output logic [31:0] crc_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= CRC_PRESET;
    else if (start_i) crc_q <= crc_byte(CRC_PRESET, byte_i);
    else if (adv_i)   crc_q <= crc_byte(crc_q, byte_i);
  end

  assign crc_o = crc_q;

  AST_CRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i || adv_i) |=> $stable(crc_q)); // R1
endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
  parameter int HALF_W = 3,
  localparam int N_REGS = 1 << HALF_W,
  localparam int REG_W  = 1 << HALF_W,
  localparam int IDX_W  = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [HALF_W-1:0] waddr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              snap_load_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              hit_o
);
  logic [REG_W-1:0] live_q [N_REGS];
  logic [REG_W-1:0] snap_q [N_REGS];
  logic [HALF_W-1:0] reg_sel, bit_sel;

  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        live_q[r] <= '0;
        snap_q[r] <= '0;
      end else begin
        if (we_i && waddr_i == HALF_W'(r)) live_q[r] <= wdata_i;
        if (snap_load_i)                  snap_q[r] <= live_q[r];
      end
    end

    AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !snap_load_i |=> $stable(snap_q[r])); // R8
  end

  // each index half is bit-reversed before addressing
  for (genvar b = 0; b < HALF_W; b++) begin : g_rev
    assign reg_sel[b] = idx_i[HALF_W-1-b];
    assign bit_sel[b] = idx_i[IDX_W-1-b];
  end

  assign hit_o = snap_q[reg_sel][bit_sel];
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HALF_W     = 3,
  localparam int REG_W = 1 << HALF_W,
  localparam int IDX_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        byte_i,
  input  logic              byte_vld_i,
  input  logic              sof_i,
  input  logic              reg_we_i,
  input  logic [HALF_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic              done_o,
  output logic              accept_o,
  output logic              mcast_o
);
  logic        start, adv, eval, mcast, hit;
  logic [31:0] crc;
  logic        done_q, accept_q, mcast_q;

  mhf_addr_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk_i, .rst_ni, .byte_i, .byte_vld_i, .sof_i,
    .start_o(start), .adv_o(adv), .eval_o(eval), .mcast_o(mcast)
  );

  mhf_crc_engine u_crc (
    .clk_i, .rst_ni, .byte_i, .start_i(start), .adv_i(adv), .crc_o(crc)
  );

  mhf_hash_table #(.HALF_W(HALF_W)) u_tbl (
    .clk_i, .rst_ni, .we_i(reg_we_i), .waddr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .snap_load_i(start), .idx_i(crc[IDX_W-1:0]), .hit_o(hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      accept_q <= 1'b0;
      mcast_q  <= 1'b0;
    end else begin
      done_q <= eval;
      if (eval) begin
        mcast_q  <= mcast;
        accept_q <= mcast & hit;
      end
    end
  end

  assign done_o   = done_q;
  assign accept_o = accept_q;
  assign mcast_o  = mcast_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(byte_vld_i, 2)); // R6
  AST_NONMC_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !mcast_o) |-> !accept_o); // R5
endmodule

// File: tb/mcast_hash_filter_bench.sv
`timescale 1ns/1ps
module mcast_hash_filter_bench;
  typedef logic [7:0] mac_t [6];

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] byte_d = '0;
  logic       vld = 1'b0, sof = 1'b0, we = 1'b0;
  logic [2:0] waddr = '0;
  logic [7:0] wdata = '0;
  logic       done, acc, mc;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mcast_hash_filter u_mcast_hash_filter (
    .clk_i(clk), .rst_ni(rst_n), .byte_i(byte_d), .byte_vld_i(vld), .sof_i(sof),
    .reg_we_i(we), .reg_addr_i(waddr), .reg_wdata_i(wdata),
    .done_o(done), .accept_o(acc), .mcast_o(mc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input mac_t a);
    logic [31:0] r = 32'hFFFFFFFF;
    for (int j = 0; j < 48; j++) begin
      logic fb;
      fb = r[0] ^ a[j / 8][j % 8];
      r  = (r >> 1) ^ (fb ? 32'hEDB88320 : 32'h0);
    end
    return r;
  endfunction

  function automatic logic [2:0] rev3(input logic [2:0] x);
    return {x[0], x[1], x[2]};
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int r, input logic [7:0] d);
    we = 1'b1; waddr = 3'(r); wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic fill(input logic [7:0] d);
    for (int r = 0; r < 8; r++) wr(r, d);
  endtask

  // drives a frame, checks the done timing (R6), returns the decision
  task automatic send(input mac_t a, input int gap, input int extra,
                      input bit mid_wr, input int wr_reg, input logic [7:0] wr_val,
                      output logic o_acc, output logic o_mc);
    logic [3:0] dh;
    for (int i = 0; i < 6; i++) begin
      if (i > 0) for (int g = 0; g < gap; g++) begin vld = 1'b0; sof = 1'b0; step(); end
      byte_d = a[i]; vld = 1'b1; sof = (i == 0);
      if (mid_wr && i == 3) begin we = 1'b1; waddr = 3'(wr_reg); wdata = wr_val; end
      step();
      we = 1'b0;
    end
    sof = 1'b0;
    for (int t = 0; t < 4; t++) begin
      if (t < extra) begin byte_d = 8'($urandom); vld = 1'b1; end else vld = 1'b0;
      @(negedge clk);
      dh[t] = done;
      if (t == 1) begin o_acc = acc; o_mc = mc; end
      step();
    end
    vld = 1'b0;
    check("R6 done timing", 32'(dh), 32'b0010);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    mac_t a, b;
    logic ra, rm;
    logic [31:0] c;
    logic [2:0] rg, bt;

    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check("R9 done reset", 32'(done), 0);
    check("R9 accept reset", 32'(acc), 0);
    check("R9 mcast reset", 32'(mc), 0);
    rst_n = 1'b1;
    step();

    // R9/R4: table comes up empty, so a group address is dropped
    a = '{8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01};
    send(a, 0, 0, 1'b0, 0, 8'h0, ra, rm);
    check("R9 empty table mcast", 32'(rm), 1);
    check("R4 empty table rejects", 32'(ra), 0);

    // R1 R2 R3 R4: sweep of addresses, single bit and inverse tables
    for (int k = 0; k < 256; k++) begin
      for (int i = 0; i < 6; i++) a[i] = 8'($urandom);
      a[0][0] = 1'b1;
      c  = ref_crc(a);
      rg = rev3(c[2:0]);
      bt = rev3(c[5:3]);
      fill(8'h00);
      wr(int'(rg), 8'(1 << bt));
      send(a, k % 3, 0, 1'b0, 0, 8'h0, ra, rm);
      check("R3 single bit accept", 32'(ra), 1);
      fill(8'hFF);
      wr(int'(rg), ~8'(1 << bt));
      send(a, 0, 0, 1'b0, 0, 8'h0, ra, rm);
      check("R4 inverse table reject", 32'(ra), 0);
      check("R5 mcast flag", 32'(rm), 1);
    end

    // R5: unicast destinations bypass a full table
    fill(8'hFF);
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 6; i++) a[i] = 8'($urandom);
      a[0][0] = 1'b0;
      send(a, 1, 0, 1'b0, 0, 8'h0, ra, rm);
      check("R5 unicast mcast_o", 32'(rm), 0);
      check("R5 unicast accept_o", 32'(ra), 0);
    end

    // R1: bytes after the sixth are ignored; a single pulse appears
    a = '{8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h01};
    c = ref_crc(a);
    fill(8'h00);
    wr(int'(rev3(c[2:0])), 8'(1 << rev3(c[5:3])));
    send(a, 0, 3, 1'b0, 0, 8'h0, ra, rm);
    check("R1 trailing bytes ignored", 32'(ra), 1);
    // R1: bytes before any start marker are ignored
    for (int i = 0; i < 4; i++) begin byte_d = 8'($urandom); vld = 1'b1; step(); end
    vld = 1'b0;
    send(a, 0, 0, 1'b0, 0, 8'h0, ra, rm);
    check("R1 stray bytes ignored", 32'(ra), 1);

    // R7: abort a partial frame with a new start byte
    b = '{8'h01, 8'hAA, 8'h55, 8'h12, 8'h34, 8'h56};
    for (int i = 0; i < 3; i++) begin byte_d = b[i]; vld = 1'b1; sof = (i == 0); step(); end
    @(negedge clk);
    check("R7 no result from partial", 32'(done), 0);
    send(a, 0, 0, 1'b0, 0, 8'h0, ra, rm);
    check("R7 restart uses new frame", 32'(ra), 1);

    // R8: write during a frame leaves that frame alone, applies to the next
    fill(8'h00);
    send(a, 1, 0, 1'b1, int'(rev3(c[2:0])), 8'hFF, ra, rm);
    check("R8 mid-frame write ignored", 32'(ra), 0);
    send(a, 0, 0, 1'b0, 0, 8'h0, ra, rm);
    check("R8 write visible next frame", 32'(ra), 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule